// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from four source classes and hands one vectored request to a small processor sequencer. The sequencer raises a strobe at every instruction boundary, which is the point where it has finished executing one instruction and would otherwise fetch the next. In that same cycle the controller answers with a take indication, the index of the source it accepts and the handler start address. The sequencer then suspends the running program and jumps to that address. When a handler finishes, the sequencer pulses a return strobe, and the controller restores the level that was running before.

A mode input selects the behaviour at run time. In sequential mode, nothing new is accepted while any handler is in service. Requests that arrive in the meantime are held, and once service ends they are granted in the order they arrived. In nested mode, a request whose priority is strictly above the handler now running pre-empts it. A stack of in-service levels records each pre-empted handler, so every return resumes the one below it. The four classes, from highest priority to lowest, are hardware failure, timer, I/O completion and program fault.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A request input that is high at any rising clock edge sets a sticky pending flag for that source. The flag stays set, even if the input falls, until that source is taken.
- R2: `take_o` is high only in a cycle where `boundary_i` is high and a pending source qualifies under R5–R7. With nothing qualifying, `take_o` stays low and the sequencer proceeds to fetch.
- R3: While `take_o` is high, `take_src_o` carries the accepted source index and `vector_o` equals `VEC_BASE + 4 * take_src_o`.
- R4: Source indices encode priority: index 3 is hardware failure (highest), 2 is timer, 1 is I/O completion and 0 is program fault (lowest). In nested mode the controller offers the highest-index pending source.
- R5: In sequential mode (`mode_nest_i` = 0), no source is taken while a level is in service. Pending sources wait until the stack is empty.
- R6: In sequential mode, the source that became pending earliest is taken first. Sources that became pending at the same edge are taken highest index first.
- R7: In nested mode (`mode_nest_i` = 1), a source is taken only if the stack is empty or its index is strictly greater than the active level. A source whose index is equal or lower waits.
- R8: A return pulse (`ret_i`) removes the top level, and `active_lvl_o` shows the pre-empted level again. A return while the stack is empty has no effect.
- R9: When `ret_i` and `boundary_i` are high in the same cycle, the candidate is compared against the level being resumed, not the level that is ending. If a source is taken in that cycle, it replaces the top entry and the depth is unchanged.
- R10: After reset, nothing is pending, `depth_o` is 0 and `active_o` is 0. Each take pushes the accepted index: `depth_o` rises by one and `active_lvl_o` shows the new level in the next cycle. `depth_o` never exceeds `DEPTH`.
- R11: If a source's request input is still high at the edge where that source is taken, its pending flag is set again.
- R12: A change of `mode_nest_i` applies from the next boundary decision onward, whatever levels are already in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NSRC | Request lines, index = priority (R4) |
| mode_nest_i | input | 1 | 1 = nested, 0 = sequential |
| boundary_i | input | 1 | Instruction-boundary strobe from the sequencer |
| ret_i | input | 1 | Handler-return strobe |
| take_o | output | 1 | Interrupt accepted in this boundary cycle |
| take_src_o | output | $clog2(NSRC) | Index of the accepted source |
| vector_o | output | VEC_W | Handler start address |
| active_o | output | 1 | At least one level in service |
| active_lvl_o | output | $clog2(NSRC) | Level on top of the stack |
| depth_o | output | $clog2(DEPTH+1) | Number of stacked levels |

## Verification
The hardest situation to reach is a return and a boundary falling in the same cycle while another request waits. Here the decision must use the level being resumed, and the stack must swap its top entry rather than grow. The stimulus first builds a stack by hand, then leaves a lower request pending that is blocked in an ordinary boundary cycle, and finally raises the return and the boundary together. It does this once with the stack dropping to empty and once with it dropping to a lower level, and checks the depth and active level afterwards. Arrival order in sequential mode is reached by pulsing a low-priority source one edge before a high-priority one, so the older request must win against plain priority.

// File: rtl/irq_nest_pkg.sv
// Package: shared constants and source encoding for the nested interrupt controller.
// Assumes index order equals priority order (higher index = more urgent).
package irq_nest_pkg;

    typedef enum logic [1:0] {
        SRC_FAULT  = 2'd0,
        SRC_IO     = 2'd1,
        SRC_TIMER  = 2'd2,
        SRC_HWFAIL = 2'd3
    } irq_src_e;

    localparam int unsigned VEC_STRIDE_SHIFT = 2;

endpackage

// File: rtl/irq_pend_track.sv
// Module: irq_pend_track
// Holds one sticky pending flag per source and a pairwise arrival-order matrix,
// and reports which pending sources are the oldest.
// Assumes clr_i only marks sources that are currently pending.
module irq_pend_track #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] oldest_o
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] stay;
    logic [NSRC-1:0] fresh;
    logic [NSRC-1:0] older_q [NSRC];
    logic [NSRC-1:0] older_d [NSRC];

    // Next pending set: set by request, cleared by take, set dominates.
    always_comb begin
        stay   = pend_q & ~clr_i;
        pend_d = stay | req_i;
        fresh  = pend_d & ~stay;
    end

    // Order matrix: older_d[i][j] means i has waited longer than j.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            for (int j = 0; j < NSRC; j++) begin
                older_d[i][j] = stay[i] & ((stay[j] & older_q[i][j]) | fresh[j]);
            end
        end
    end

    // Register pending flags and the order matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NSRC; i++) older_q[i] <= '0;
        end else begin
            pend_q <= pend_d;
            for (int i = 0; i < NSRC; i++) older_q[i] <= older_d[i];
        end
    end

    // A pending source is oldest when no other pending source precedes it.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            oldest_o[i] = pend_q[i];
            for (int j = 0; j < NSRC; j++) begin
                if (pend_q[j] && older_q[j][i]) oldest_o[i] = 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_lvl_stack.sv
// Module: irq_lvl_stack
// Stack of in-service levels with a count. Pop is applied before push, so a
// same-cycle pop and push replaces the top. Exposes both the current top and
// the top as it stands after this cycle's pop.
// Assumes push_i is only raised when eff_room_o is high.
module irq_lvl_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LW    = 2,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] push_lvl_i,
    output logic [CW-1:0] depth_o,
    output logic          top_valid_o,
    output logic [LW-1:0] top_lvl_o,
    output logic          eff_valid_o,
    output logic [LW-1:0] eff_lvl_o,
    output logic          eff_room_o
);

    logic [LW-1:0] lvl_q [DEPTH];
    logic [CW-1:0] depth_q;
    logic [CW-1:0] eff_depth;
    logic          pop_eff;

    // Depth after the pop of this cycle; a pop on an empty stack is dropped.
    always_comb begin
        pop_eff   = pop_i && (depth_q != '0);
        eff_depth = pop_eff ? depth_q - CW'(1) : depth_q;
    end

    // Read the current top and the post-pop top.
    always_comb begin
        top_lvl_o = '0;
        eff_lvl_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == CW'(i + 1))   top_lvl_o = lvl_q[i];
            if (eff_depth == CW'(i + 1)) eff_lvl_o = lvl_q[i];
        end
    end

    assign top_valid_o = (depth_q != '0);
    assign eff_valid_o = (eff_depth != '0);
    assign eff_room_o  = (eff_depth < CW'(DEPTH));
    assign depth_o     = depth_q;

    // Update the depth count.
    always_ff @(posedge clk) begin
        if (!rst_n) depth_q <= '0;
        else        depth_q <= push_i ? eff_depth + CW'(1) : eff_depth;
    end

    // Write a pushed level into the slot just above the post-pop top.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                lvl_q[g] <= '0;
            else if (push_i && eff_depth == CW'(g))    lvl_q[g] <= push_lvl_i;
        end
    end

endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Chooses the candidate source (highest priority in nested mode, oldest in
// sequential mode) and decides whether it is accepted at this boundary.
// Assumes oldest_i is non-empty whenever pend_i is non-empty.
module irq_pick #(
    parameter int unsigned NSRC = 4,
    parameter int unsigned LW   = 2
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] oldest_i,
    input  logic            nest_i,
    input  logic            boundary_i,
    input  logic            eff_valid_i,
    input  logic [LW-1:0]   eff_lvl_i,
    input  logic            eff_room_i,
    output logic            take_o,
    output logic [LW-1:0]   src_o
);

    function automatic logic [LW-1:0] top_index(input logic [NSRC-1:0] m);
        logic [LW-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++) if (m[i]) r = LW'(i);
        return r;
    endfunction

    logic allowed;

    // Candidate per mode.
    always_comb begin
        src_o = nest_i ? top_index(pend_i) : top_index(oldest_i);
    end

    // Acceptance rule against the level that will be active after any return.
    always_comb begin
        if (nest_i) allowed = !eff_valid_i || (src_o > eff_lvl_i);
        else        allowed = !eff_valid_i;
        take_o = boundary_i && (|pend_i) && allowed && eff_room_i;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
// Module: irq_nest_ctrl (top)
// Nested/sequential priority interrupt controller. Answers an instruction-
// boundary strobe in the same cycle with take, source and vector; tracks
// in-service levels on a stack popped by the return strobe.
// Assumes the sequencer jumps to vector_o whenever take_o is high.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int unsigned NSRC     = 4,
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0100,
    localparam int unsigned LW      = $clog2(NSRC),
    localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req_i,
    input  logic             mode_nest_i,
    input  logic             boundary_i,
    input  logic             ret_i,
    output logic             take_o,
    output logic [LW-1:0]    take_src_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             active_o,
    output logic [LW-1:0]    active_lvl_o,
    output logic [CW-1:0]    depth_o
);

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] oldest;
    logic [NSRC-1:0] clr;
    logic            eff_valid;
    logic [LW-1:0]   eff_lvl;
    logic            eff_room;
    logic            take;
    logic [LW-1:0]   src;

    irq_pend_track #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .clr_i    (clr),
        .pend_o   (pend),
        .oldest_o (oldest)
    );

    irq_pick #(.NSRC(NSRC), .LW(LW)) u_pick (
        .pend_i      (pend),
        .oldest_i    (oldest),
        .nest_i      (mode_nest_i),
        .boundary_i  (boundary_i),
        .eff_valid_i (eff_valid),
        .eff_lvl_i   (eff_lvl),
        .eff_room_i  (eff_room),
        .take_o      (take),
        .src_o       (src)
    );

    irq_lvl_stack #(.DEPTH(DEPTH), .LW(LW)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (take),
        .pop_i       (ret_i),
        .push_lvl_i  (src),
        .depth_o     (depth_o),
        .top_valid_o (active_o),
        .top_lvl_o   (active_lvl_o),
        .eff_valid_o (eff_valid),
        .eff_lvl_o   (eff_lvl),
        .eff_room_o  (eff_room)
    );

    // Acknowledge: clear the pending flag of the taken source.
    always_comb begin
        clr = '0;
        if (take) clr[src] = 1'b1;
    end

    // Outputs of the take handshake and the handler address.
    always_comb begin
        take_o     = take;
        take_src_o = src;
        vector_o   = VEC_BASE + (VEC_W'(src) << VEC_STRIDE_SHIFT);
    end

endmodule

// File: rtl/irq_nest_checker.sv
// Module: irq_nest_checker
// Port-level properties of irq_nest_ctrl, attached by bind below.
module irq_nest_checker #(
    parameter int unsigned NSRC  = 4,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned VEC_W = 16,
    localparam int unsigned LW   = $clog2(NSRC),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_nest_i,
    input logic             boundary_i,
    input logic             ret_i,
    input logic             take_o,
    input logic [LW-1:0]    take_src_o,
    input logic             active_o,
    input logic [LW-1:0]    active_lvl_o,
    input logic [CW-1:0]    depth_o
);

    p_take_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> boundary_i);

    p_seq_idle_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !mode_nest_i) |-> (depth_o == '0 || (ret_i && depth_o == CW'(1))));

    p_nest_strictly_higher_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && mode_nest_i && !ret_i && depth_o != '0) |-> (take_src_o > active_lvl_o));

    p_pop_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !take_o && depth_o != '0) |=> (depth_o == $past(depth_o) - CW'(1)));

    p_empty_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !take_o && depth_o == '0) |=> (depth_o == '0));

    p_replace_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ret_i && depth_o != '0) |=>
            (depth_o == $past(depth_o) && active_lvl_o == $past(take_src_o)));

    p_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !ret_i) |=>
            (depth_o == $past(depth_o) + CW'(1) && active_lvl_o == $past(take_src_o)));

    p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o <= CW'(DEPTH)) && (active_o == (depth_o != '0)));

endmodule

bind irq_nest_ctrl irq_nest_checker #(
    .NSRC  (NSRC),
    .DEPTH (DEPTH),
    .VEC_W (VEC_W)
) u_irq_nest_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_nest_i  (mode_nest_i),
    .boundary_i   (boundary_i),
    .ret_i        (ret_i),
    .take_o       (take_o),
    .take_src_o   (take_src_o),
    .active_o     (active_o),
    .active_lvl_o (active_lvl_o),
    .depth_o      (depth_o)
);

// File: tb/irq_nest_ctrl_bench.sv
// Directed bench for irq_nest_ctrl: one task per scenario.
module irq_nest_ctrl_bench;

    localparam logic [15:0] VB = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_i = '0;
    logic        mode_nest_i = 1'b0;
    logic        boundary_i = 1'b0;
    logic        ret_i = 1'b0;
    logic        take_o;
    logic [1:0]  take_src_o;
    logic [15:0] vector_o;
    logic        active_o;
    logic [1:0]  active_lvl_o;
    logic [2:0]  depth_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_nest_ctrl #(.NSRC(4), .DEPTH(4), .VEC_W(16), .VEC_BASE(VB)) u_irq_nest_ctrl (
        .clk (clk), .rst_n (rst_n), .req_i (req_i), .mode_nest_i (mode_nest_i),
        .boundary_i (boundary_i), .ret_i (ret_i), .take_o (take_o),
        .take_src_o (take_src_o), .vector_o (vector_o), .active_o (active_o),
        .active_lvl_o (active_lvl_o), .depth_o (depth_o)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // One boundary cycle, optionally with a return; checks the take result.
    task automatic boundary(input bit ret, input bit exp_take, input int exp_src, input string rq);
        @(negedge clk);
        boundary_i = 1'b1;
        ret_i      = ret;
        #2;
        chk(rq, "take_o", int'(take_o), int'(exp_take));
        if (exp_take) begin
            chk(rq, "take_src_o", int'(take_src_o), exp_src);
            chk("R3", "vector_o", int'(vector_o), int'(VB) + 4 * exp_src);
        end
        @(posedge clk);
        #1;
        boundary_i = 1'b0;
        ret_i      = 1'b0;
    endtask

    task automatic ret_pulse();
        @(negedge clk);
        ret_i = 1'b1;
        @(posedge clk);
        #1;
        ret_i = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        req_i = m;
        @(posedge clk);
        #1;
        req_i = '0;
    endtask

    task automatic state(input string rq, input int exp_depth, input int exp_lvl);
        #1;
        chk(rq, "depth_o", int'(depth_o), exp_depth);
        chk(rq, "active_o", int'(active_o), int'(exp_depth != 0));
        if (exp_depth != 0) chk(rq, "active_lvl_o", int'(active_lvl_o), exp_lvl);
    endtask

    task automatic t_reset();
        state("R10", 0, 0);
        boundary(1'b0, 1'b0, 0, "R2");
    endtask

    task automatic t_sequential();
        mode_nest_i = 1'b0;
        pulse(4'b0001);
        pulse(4'b1000);
        repeat (5) @(posedge clk);
        boundary(1'b0, 1'b1, 0, "R6");          // older fault beats newer hw failure
        state("R10", 1, 0);
        boundary(1'b0, 1'b0, 0, "R5");          // masked while in service
        ret_pulse();
        state("R8", 0, 0);
        boundary(1'b0, 1'b1, 3, "R1");          // sticky pending survives
        ret_pulse();
        pulse(4'b0110);
        boundary(1'b0, 1'b1, 2, "R6");          // same-edge tie: higher index
        ret_pulse();
        boundary(1'b0, 1'b1, 1, "R6");
        ret_pulse();
        state("R8", 0, 0);
    endtask

    task automatic t_nested();
        mode_nest_i = 1'b1;
        pulse(4'b0010);
        boundary(1'b0, 1'b1, 1, "R4");
        pulse(4'b0001);
        boundary(1'b0, 1'b0, 0, "R7");          // lower waits
        pulse(4'b0010);
        boundary(1'b0, 1'b0, 0, "R7");          // equal waits
        pulse(4'b0100);
        boundary(1'b0, 1'b1, 2, "R7");
        state("R10", 2, 2);
        pulse(4'b1000);
        boundary(1'b0, 1'b1, 3, "R4");
        state("R10", 3, 3);
        ret_pulse();
        state("R8", 2, 2);
        ret_pulse();
        state("R8", 1, 1);
        boundary(1'b0, 1'b0, 0, "R7");
        ret_pulse();
        boundary(1'b0, 1'b1, 1, "R4");          // highest of {1,0}
        ret_pulse();
        boundary(1'b0, 1'b1, 0, "R4");
        ret_pulse();
        ret_pulse();                             // empty-stack return
        state("R8", 0, 0);
        boundary(1'b0, 1'b0, 0, "R2");
    endtask

    task automatic t_same_cycle();
        mode_nest_i = 1'b1;
        pulse(4'b0100);
        boundary(1'b0, 1'b1, 2, "R9");
        pulse(4'b0010);
        boundary(1'b0, 1'b0, 0, "R9");          // blocked by level 2
        boundary(1'b1, 1'b1, 1, "R9");          // compared against empty stack
        state("R9", 1, 1);
        pulse(4'b1000);
        boundary(1'b0, 1'b1, 3, "R9");
        state("R9", 2, 3);
        pulse(4'b0100);
        boundary(1'b1, 1'b1, 2, "R9");          // resumes 1, 2 > 1, replaces top
        state("R9", 2, 2);
        ret_pulse();
        state("R9", 1, 1);
        ret_pulse();
        state("R9", 0, 0);
    endtask

    task automatic t_rearm();
        mode_nest_i = 1'b0;
        @(negedge clk);
        req_i = 4'b0010;
        repeat (2) @(posedge clk);
        boundary(1'b0, 1'b1, 1, "R11");         // request still high at take edge
        @(negedge clk);
        req_i = '0;
        ret_pulse();
        boundary(1'b0, 1'b1, 1, "R11");
        ret_pulse();
        boundary(1'b0, 1'b0, 0, "R11");
    endtask

    task automatic t_mode_switch();
        mode_nest_i = 1'b1;
        pulse(4'b0010);
        boundary(1'b0, 1'b1, 1, "R12");
        pulse(4'b1000);
        @(negedge clk);
        mode_nest_i = 1'b0;
        boundary(1'b0, 1'b0, 0, "R12");
        @(negedge clk);
        mode_nest_i = 1'b1;
        boundary(1'b0, 1'b1, 3, "R12");
        state("R12", 2, 3);
        ret_pulse();
        ret_pulse();
        state("R12", 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sequential();
        t_nested();
        t_same_cycle();
        t_rearm();
        t_mode_switch();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule